// File: doc/BRIEF.md
# General-Purpose Pad Bank Controller with Event Detection

This block controls a bank of general-purpose pads through a 32-bit memory-mapped read/write port. Every pad owns a 16-byte window of registers that sets its direction and output level, stores its function select, pull and open-drain fields, and chooses how its input raises an event. Pad electrical behaviour is abstracted to one logical input, one output value and one output enable per pad.

Pad inputs are brought into the clock domain by a two-flop synchroniser. Each pad can watch for rising edges, falling edges, both edges, a high level or a low level. Events land in a shared status array of 32-bit words, one bit per pad, which software clears by writing ones. A single interrupt output is the OR of every status bit. A pad configured for direct interrupt routing never sets its bit in the shared array.

Software reads a register by presenting a request with the write strobe low; the data appears on the read bus one clock later. Writes take effect at the clock edge that samples the request.

Top module: `gpio_pad_bank`

## Requirements
- R1: Pad p owns the byte addresses p*16 to p*16+15. Configuration word A sits at +0x0, configuration word B at +0x4, the level/direction register at +0x8 and an auxiliary word at +0xC. Words A, B and the auxiliary word read back all 32 written bits. Read data is registered and is valid one cycle after the request. Windows of pads at or above NUM_PADS read as zero and ignore writes.
- R2: After reset, every register reads zero except the level/direction register, which reads 0x6. The interrupt output and every pad output enable are low.
- R3: In the level/direction register, bit 2 is an active-low input enable, bit 1 is an active-low output enable, and bit 0 is the level; bits 31:3 read zero. Reading bit 0 returns the stored level when bit 1 is 0. It returns the synchronised pad input when bit 1 is 1 and bit 2 is 0. It returns the stored level when both enables are 1.
- R4: With word A bits 2:0 equal to 0 and the output enable active, the pad is driven and its output equals bit 0. With word A bit 31 set (open drain), the pad is driven low only while bit 0 is 0, and the enable is released while bit 0 is 1.
- R5: A pad input passes through two flops. A change applied in cycle 0 is first seen by a register read captured at the third clock edge. An edge event from that change is first visible on the interrupt output after the third edge.
- R6: In edge mode (word A bit 24 = 0), bit 25 detects rising edges and bit 26 detects falling edges, and both set together detect either edge. With bits 26:24 all zero, the pad raises no event.
- R7: In level mode (word A bit 24 = 1), bit 25 sets the status bit while the input is high, and bit 26 sets it while the input is low.
- R8: The status bit of pad p is bit p%32 of the word at 0x800 + (p/32)*4. Bits with no pad and words beyond the last pad read zero.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A clear wins over an event in the same cycle, so a level-mode pad whose condition persists reads 0 once directly after the clear and 1 in the following read.
- R10: A pad with word A bit 27 (direct interrupt) set never sets its status bit, whatever its trigger bits are.
- R11: The interrupt output is high exactly while at least one status bit is set.
- R12: When word A bits 2:0 are nonzero, the pad output enable stays low whatever the level/direction register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write strobe (1 = write, 0 = read) |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| pad_in_i | input | NUM_PADS | Logical pad input levels (asynchronous) |
| pad_out_o | output | NUM_PADS | Logical pad output values |
| pad_oe_o | output | NUM_PADS | Pad output enables, active high |
| irq_o | output | 1 | Combined interrupt, OR of all status bits |

## Verification
The bench builds the block with NUM_PADS = 40 and ADDR_W = 12. This gives two status words, and the second word is only partly populated. Pads 31, 32 and 39 exercise the word boundary and the unused upper bits. The third status word and the windows of pads 40 and up fall in the unmapped area and must read zero. With only two words, events in separate words can be set and cleared one word at a time to show that the combined interrupt follows the OR across both words.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    REG_CFG_A = 2'd0,
    REG_CFG_B = 2'd1,
    REG_LVL   = 2'd2,
    REG_AUX   = 2'd3
  } pad_reg_e;

  localparam int unsigned WIN_SHIFT      = 4;   // 16-byte window per pad
  localparam int unsigned WORD_BITS      = 32;

  localparam int unsigned FSEL_W         = 3;
  localparam int unsigned TRIG_LVL_BIT   = 24;
  localparam int unsigned TRIG_HI_BIT    = 25;
  localparam int unsigned TRIG_LO_BIT    = 26;
  localparam int unsigned DIRECT_BIT     = 27;
  localparam int unsigned OPEN_DRAIN_BIT = 31;

  localparam int unsigned LV_LEVEL = 0;
  localparam int unsigned LV_OE_N  = 1;
  localparam int unsigned LV_IE_N  = 2;
  localparam logic [2:0]  LV_RESET = 3'b110;

  typedef struct packed {
    logic level_mode;
    logic hi_en;
    logic lo_en;
    logic direct;
  } trig_cfg_t;

  function automatic trig_cfg_t decode_trig(logic [31:0] cfg);
    trig_cfg_t t;
    t.level_mode = cfg[TRIG_LVL_BIT];
    t.hi_en      = cfg[TRIG_HI_BIT];
    t.lo_en      = cfg[TRIG_LO_BIT];
    t.direct     = cfg[DIRECT_BIT];
    return t;
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic q_prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign q_o      = chain_q[STAGES-1];
  assign q_prev_o = prev_q;
endmodule

// File: rtl/gpio_pad_event.sv
module gpio_pad_event
  import gpio_bank_pkg::*;
(
  input  logic      cur_i,
  input  logic      prev_i,
  input  trig_cfg_t trig_i,
  output logic      evt_o
);
  logic rise, fall;

  assign rise = cur_i & ~prev_i;
  assign fall = ~cur_i & prev_i;

  always_comb begin
    if (trig_i.direct)          evt_o = 1'b0;
    else if (trig_i.level_mode) evt_o = (trig_i.hi_en & cur_i) | (trig_i.lo_en & ~cur_i);
    else                        evt_o = (trig_i.hi_en & rise) | (trig_i.lo_en & fall);
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  pad_reg_e    sel_i,
  input  logic [31:0] wdata_i,
  input  logic        pad_in_i,
  output logic [31:0] cfg_a_o,
  output logic [31:0] cfg_b_o,
  output logic [31:0] aux_o,
  output logic [31:0] lv_rd_o,
  output logic        pad_out_o,
  output logic        pad_oe_o,
  output logic        evt_o
);
  logic [31:0] cfg_a_q, cfg_b_q, aux_q;
  logic [2:0]  lv_q;
  logic        in_sync, in_prev;
  logic        gpio_fn, drive_en, open_drain, rd_level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_a_q <= '0;
      cfg_b_q <= '0;
      aux_q   <= '0;
      lv_q    <= LV_RESET;
    end else if (wr_i) begin
      unique case (sel_i)
        REG_CFG_A: cfg_a_q <= wdata_i;
        REG_CFG_B: cfg_b_q <= wdata_i;
        REG_LVL:   lv_q    <= wdata_i[2:0];
        REG_AUX:   aux_q   <= wdata_i;
        default:   ;
      endcase
    end
  end

  gpio_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (pad_in_i),
    .q_o      (in_sync),
    .q_prev_o (in_prev)
  );

  gpio_pad_event u_evt (
    .cur_i  (in_sync),
    .prev_i (in_prev),
    .trig_i (decode_trig(cfg_a_q)),
    .evt_o  (evt_o)
  );

  // pad is a plain GPIO only with function select 0
  assign gpio_fn    = (cfg_a_q[FSEL_W-1:0] == '0);
  assign drive_en   = gpio_fn & ~lv_q[LV_OE_N];
  assign open_drain = cfg_a_q[OPEN_DRAIN_BIT];
  assign pad_oe_o   = drive_en & (~open_drain | ~lv_q[LV_LEVEL]);
  assign pad_out_o  = drive_en & ~open_drain & lv_q[LV_LEVEL];

  always_comb begin
    if (!lv_q[LV_OE_N])      rd_level = lv_q[LV_LEVEL];
    else if (!lv_q[LV_IE_N]) rd_level = in_sync;
    else                     rd_level = lv_q[LV_LEVEL];
  end

  assign cfg_a_o = cfg_a_q;
  assign cfg_b_o = cfg_b_q;
  assign aux_o   = aux_q;
  assign lv_rd_o = {29'd0, lv_q[LV_IE_N], lv_q[LV_OE_N], rd_level};

  a_r4_od_low_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o && open_drain) |-> !pad_out_o);

  a_r12_fsel_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_a_q[FSEL_W-1:0] != '0) |-> !pad_oe_o);

  a_r10_direct_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_a_q[DIRECT_BIT] |-> !evt_o);

  a_r5_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_a_q[TRIG_LVL_BIT] && evt_o) |-> (in_sync != in_prev));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned NUM_PADS = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] set_i,
  input  logic [NUM_PADS-1:0] clr_i,
  output logic [NUM_PADS-1:0] st_o,
  output logic                irq_o
);
  logic [NUM_PADS-1:0] st_q;

  // clear has priority over a coincident event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q | set_i) & ~clr_i;
  end

  assign st_o  = st_q;
  assign irq_o = |st_q;

  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((st_q & $past(clr_i)) == '0));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~st_q & $past(st_q & ~clr_i)) == '0));

  a_r11_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|set_i));
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PADS    = 40,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PADS-1:0] pad_in_i,
  output logic [NUM_PADS-1:0] pad_out_o,
  output logic [NUM_PADS-1:0] pad_oe_o,
  output logic                irq_o
);
  localparam int unsigned NUM_WORDS  = (NUM_PADS + WORD_BITS - 1) / WORD_BITS;
  localparam int unsigned PAD_SEL_W  = ADDR_W - 1 - WIN_SHIFT;
  localparam int unsigned WORD_SEL_W = ADDR_W - 3;
  localparam int unsigned PIDX_W     = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam int unsigned WIDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic                  is_stat, wr_cycle, rd_cycle;
  logic [PAD_SEL_W-1:0]  pad_sel;
  logic [WORD_SEL_W-1:0] word_sel;
  pad_reg_e              reg_sel;
  logic [PIDX_W-1:0]     pidx;
  logic [WIDX_W-1:0]     widx;
  logic                  unused_addr;

  assign is_stat     = addr_i[ADDR_W-1];
  assign pad_sel     = addr_i[ADDR_W-2:WIN_SHIFT];
  assign word_sel    = addr_i[ADDR_W-2:2];
  assign reg_sel     = pad_reg_e'(addr_i[3:2]);
  assign pidx        = pad_sel[PIDX_W-1:0];
  assign widx        = word_sel[WIDX_W-1:0];
  assign wr_cycle    = req_i & we_i;
  assign rd_cycle    = req_i & ~we_i;
  assign unused_addr = ^addr_i[1:0];

  logic [31:0]                  cfg_a_arr [NUM_PADS];
  logic [31:0]                  cfg_b_arr [NUM_PADS];
  logic [31:0]                  aux_arr   [NUM_PADS];
  logic [31:0]                  lv_arr    [NUM_PADS];
  logic [NUM_PADS-1:0]          evt, clr, st;
  logic [NUM_WORDS*WORD_BITS-1:0] st_ext;
  logic [31:0]                  st_word   [NUM_WORDS];

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    gpio_pad_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_pad (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_cycle & ~is_stat & (pad_sel == PAD_SEL_W'(p))),
      .sel_i     (reg_sel),
      .wdata_i   (wdata_i),
      .pad_in_i  (pad_in_i[p]),
      .cfg_a_o   (cfg_a_arr[p]),
      .cfg_b_o   (cfg_b_arr[p]),
      .aux_o     (aux_arr[p]),
      .lv_rd_o   (lv_arr[p]),
      .pad_out_o (pad_out_o[p]),
      .pad_oe_o  (pad_oe_o[p]),
      .evt_o     (evt[p])
    );

    assign clr[p] = wr_cycle & is_stat
                  & (word_sel == WORD_SEL_W'(p / WORD_BITS))
                  & wdata_i[p % WORD_BITS];
  end

  gpio_irq_status #(.NUM_PADS(NUM_PADS)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt),
    .clr_i  (clr),
    .st_o   (st),
    .irq_o  (irq_o)
  );

  always_comb begin
    st_ext                = '0;
    st_ext[NUM_PADS-1:0]  = st;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign st_word[w] = st_ext[w*WORD_BITS +: WORD_BITS];
  end

  logic [31:0] rd_d, rdata_q;

  always_comb begin
    rd_d = '0;
    if (is_stat) begin
      if (word_sel < WORD_SEL_W'(NUM_WORDS)) rd_d = st_word[widx];
    end else if (pad_sel < PAD_SEL_W'(NUM_PADS)) begin
      unique case (reg_sel)
        REG_CFG_A: rd_d = cfg_a_arr[pidx];
        REG_CFG_B: rd_d = cfg_b_arr[pidx];
        REG_LVL:   rd_d = lv_arr[pidx];
        REG_AUX:   rd_d = aux_arr[pidx];
        default:   rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (rd_cycle) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;

  a_r1_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_cycle |=> $stable(rdata_o));
endmodule

// File: tb/gpio_pad_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_pad_bank_tb_top;
  localparam int NP = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          req, we;
  logic [11:0]   addr;
  logic [31:0]   wdata, rdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe;
  logic          irq;

  gpio_pad_bank #(.NUM_PADS(NP), .ADDR_W(12), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_cfg_a [NP];
  logic [31:0] m_cfg_b [NP];
  logic [31:0] m_aux   [NP];
  logic [2:0]  m_lv    [NP];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  function automatic logic [11:0] pad_addr(int p, int r);
    return 12'(p * 16 + r * 4);
  endfunction

  function automatic logic [11:0] st_addr(int w);
    return 12'(2048 + w * 4);
  endfunction

  function automatic logic [31:0] exp_lv_rd(logic [2:0] lv, logic in);
    logic b0;
    if (!lv[1])      b0 = lv[0];
    else if (!lv[2]) b0 = in;
    else             b0 = lv[0];
    return {29'd0, lv[2], lv[1], b0};
  endfunction

  function automatic logic exp_oe(logic [31:0] cfg, logic [2:0] lv);
    logic en;
    en = (cfg[2:0] == 3'd0) && !lv[1];
    return en && (!cfg[31] || !lv[0]);
  endfunction

  function automatic logic exp_out(logic [31:0] cfg, logic [2:0] lv);
    return (cfg[2:0] == 3'd0) && !lv[1] && !cfg[31] && lv[0];
  endfunction

  // expected sticky status after input moves v0 -> v1 under trigger code {lo,hi,lvl}
  function automatic logic exp_evt(logic [2:0] trig, logic dir, logic v0, logic v1);
    if (dir) return 1'b0;
    if (trig[0]) return (trig[1] && (v0 || v1)) || (trig[2] && (!v0 || !v1));
    return (trig[1] && !v0 && v1) || (trig[2] && v0 && !v1);
  endfunction

  task automatic clear_all();
    bus_wr(st_addr(0), 32'hFFFF_FFFF);
    bus_wr(st_addr(1), 32'hFFFF_FFFF);
  endtask

  task automatic event_case(input int p, input logic [2:0] trig, input logic dir, input logic v0);
    logic [31:0] d, d2;
    logic e;
    string tag;
    pad_in[p] = v0;
    repeat (4) @(negedge clk);
    clear_all();
    bus_wr(pad_addr(p, 0), {4'd0, dir, trig, 24'd0});
    pad_in[p] = ~v0;
    repeat (5) @(negedge clk);
    e = exp_evt(trig, dir, v0, ~v0);
    tag = dir ? "R10" : (trig[0] ? "R7" : "R6");
    bus_rd(st_addr(p / 32), d);
    check(tag, d, e ? (32'd1 << (p % 32)) : 32'd0);
    bus_rd(st_addr(1 - p / 32), d2);
    check("R8", d2, 32'd0);
    check("R11", {31'd0, irq}, {31'd0, e});
    bus_wr(pad_addr(p, 0), 32'd0);
    m_cfg_a[p] = 32'd0;
    clear_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p, k;
    logic [2:0] trig_list [6];
    void'($urandom(32'h5eed_1234));
    trig_list[0] = 3'b000; trig_list[1] = 3'b010; trig_list[2] = 3'b100;
    trig_list[3] = 3'b110; trig_list[4] = 3'b011; trig_list[5] = 3'b101;
    for (int i = 0; i < NP; i++) begin
      m_cfg_a[i] = 0; m_cfg_b[i] = 0; m_aux[i] = 0; m_lv[i] = 3'b110;
    end
    rst_n = 0; req = 0; we = 0; addr = 0; wdata = 0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2: reset state
    check("R2", {31'd0, irq}, 32'd0);
    check("R2", {31'd0, |pad_oe}, 32'd0);
    bus_rd(pad_addr(0, 2), d);  check("R2", d, 32'h6);
    bus_rd(pad_addr(39, 0), d); check("R2", d, 32'h0);
    bus_rd(pad_addr(17, 3), d); check("R2", d, 32'h0);
    bus_rd(st_addr(0), d);      check("R2", d, 32'h0);
    bus_rd(st_addr(1), d);      check("R2", d, 32'h0);

    // R1: window layout, separation of neighbours
    bus_wr(pad_addr(5, 1), 32'hA5A5_1234);
    bus_wr(pad_addr(5, 3), 32'h0F0F_F0F0);
    bus_wr(pad_addr(6, 1), 32'h1111_2222);
    bus_rd(pad_addr(5, 1), d); check("R1", d, 32'hA5A5_1234);
    bus_rd(pad_addr(5, 3), d); check("R1", d, 32'h0F0F_F0F0);
    bus_rd(pad_addr(6, 1), d); check("R1", d, 32'h1111_2222);
    m_cfg_b[5] = 32'hA5A5_1234; m_aux[5] = 32'h0F0F_F0F0; m_cfg_b[6] = 32'h1111_2222;
    // R3: upper bits read zero
    bus_wr(pad_addr(8, 2), 32'hFFFF_FFFF); m_lv[8] = 3'b111;
    bus_rd(pad_addr(8, 2), d); check("R3", d, 32'h7);
    // R1/R8: unmapped windows and words
    bus_wr(pad_addr(50, 0), 32'hFFFF_FFFF);
    bus_rd(pad_addr(50, 0), d); check("R1", d, 32'h0);
    bus_rd(st_addr(2), d);      check("R8", d, 32'h0);

    // constrained random register traffic
    pad_in = NP'({$urandom(), $urandom()});
    repeat (4) @(negedge clk);
    for (int i = 0; i < 160; i++) begin
      p = $urandom_range(NP - 1, 0);
      k = $urandom_range(3, 0);
      d = $urandom();
      if (k == 0 && $urandom_range(1, 0) == 1) d[2:0] = 3'd0;
      bus_wr(pad_addr(p, k), d);
      case (k)
        0: m_cfg_a[p] = d;
        1: m_cfg_b[p] = d;
        2: m_lv[p]    = d[2:0];
        default: m_aux[p] = d;
      endcase
      bus_rd(pad_addr(p, k), d);
      case (k)
        0: check("R1", d, m_cfg_a[p]);
        1: check("R1", d, m_cfg_b[p]);
        2: check("R3", d, exp_lv_rd(m_lv[p], pad_in[p]));
        default: check("R1", d, m_aux[p]);
      endcase
      check("R4", {30'd0, pad_oe[p], pad_out[p]},
            {30'd0, exp_oe(m_cfg_a[p], m_lv[p]), exp_out(m_cfg_a[p], m_lv[p])});
    end
    for (int i = 0; i < NP; i++) begin
      bus_wr(pad_addr(i, 0), 32'd0);
      m_cfg_a[i] = 0;
    end
    clear_all();
    bus_rd(st_addr(0), d); check("R9", d, 32'h0);
    bus_rd(st_addr(1), d); check("R9", d, 32'h0);
    check("R11", {31'd0, irq}, 32'd0);

    // R4/R12 directed drive cases on pad 3
    bus_wr(pad_addr(3, 2), 32'h0);
    check("R4", {30'd0, pad_oe[3], pad_out[3]}, 32'b10);
    bus_wr(pad_addr(3, 2), 32'h1);
    check("R4", {30'd0, pad_oe[3], pad_out[3]}, 32'b11);
    bus_wr(pad_addr(3, 0), 32'h8000_0000);
    check("R4", {30'd0, pad_oe[3], pad_out[3]}, 32'b00);
    bus_wr(pad_addr(3, 2), 32'h0);
    check("R4", {30'd0, pad_oe[3], pad_out[3]}, 32'b10);
    bus_wr(pad_addr(3, 0), 32'h0000_0001);
    bus_wr(pad_addr(3, 2), 32'h1);
    check("R12", {30'd0, pad_oe[3], pad_out[3]}, 32'b00);
    bus_wr(pad_addr(3, 0), 32'h0000_0006);
    check("R12", {30'd0, pad_oe[3], pad_out[3]}, 32'b00);
    bus_wr(pad_addr(3, 0), 32'h0);

    // R5: two-flop input path seen through register reads
    pad_in[7] = 1'b0;
    bus_wr(pad_addr(7, 2), 32'h2);
    repeat (4) @(negedge clk);
    pad_in[7] = 1'b1;
    bus_rd(pad_addr(7, 2), d); check("R5", d, 32'h2);
    bus_rd(pad_addr(7, 2), d); check("R5", d, 32'h2);
    bus_rd(pad_addr(7, 2), d); check("R5", d, 32'h3);

    // R5: rising edge reaches irq after the third edge
    pad_in[9] = 1'b0;
    bus_wr(pad_addr(9, 0), 32'h0200_0000);
    repeat (4) @(negedge clk);
    clear_all();
    pad_in[9] = 1'b1;
    repeat (2) @(negedge clk);
    check("R5", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R5", {31'd0, irq}, 32'd1);
    bus_wr(pad_addr(9, 0), 32'h0);
    clear_all();

    // R6/R7/R10/R8: trigger matrix, word-boundary pads
    for (int t = 0; t < 6; t++) begin
      event_case(31, trig_list[t], 1'b0, 1'b0);
      event_case(32, trig_list[t], 1'b0, 1'b1);
      event_case(39, trig_list[t], 1'b0, 1'b0);
      event_case(0,  trig_list[t], 1'b1, 1'b1);
    end
    for (int i = 0; i < 30; i++) begin
      event_case($urandom_range(NP - 1, 0), trig_list[$urandom_range(5, 0)],
                 1'($urandom_range(3, 0) == 0), 1'($urandom_range(1, 0)));
    end

    // R9: write-zero, clear priority and level re-set
    pad_in[33] = 1'b1;
    bus_wr(pad_addr(33, 0), 32'h0300_0000);
    repeat (4) @(negedge clk);
    bus_rd(st_addr(1), d); check("R9", d, 32'h2);
    bus_wr(st_addr(1), 32'h0);
    bus_rd(st_addr(1), d); check("R9", d, 32'h2);
    bus_wr(st_addr(1), 32'h2);
    bus_rd(st_addr(1), d); check("R9", d, 32'h0);
    bus_rd(st_addr(1), d); check("R9", d, 32'h2);
    bus_wr(pad_addr(33, 0), 32'h0);
    clear_all();
    bus_rd(st_addr(1), d); check("R9", d, 32'h0);

    // R11: OR across both words
    pad_in[2] = 1'b0; pad_in[35] = 1'b0;
    bus_wr(pad_addr(2, 0), 32'h0200_0000);
    bus_wr(pad_addr(35, 0), 32'h0200_0000);
    repeat (4) @(negedge clk);
    clear_all();
    pad_in[2] = 1'b1; pad_in[35] = 1'b1;
    repeat (5) @(negedge clk);
    check("R11", {31'd0, irq}, 32'd1);
    bus_wr(st_addr(0), 32'h4);
    check("R11", {31'd0, irq}, 32'd1);
    bus_wr(st_addr(1), 32'h8);
    check("R11", {31'd0, irq}, 32'd0);
    bus_wr(pad_addr(2, 0), 32'h0);
    bus_wr(pad_addr(35, 0), 32'h0);

    done = 1;
    report();
    $finish;
  end
endmodule